// File: doc/BRIEF.md
# Configuration-Space Window Base Decoder

This block holds the 64-bit base register of a memory-mapped configuration window, such as a PCI Express ECAM region. Software writes the register through a plain write port with per-byte enables and can read it back at any time. A registered decode stage turns the register into three values: a window enable, a window base and a window size. A comparator flags whether an incoming 64-bit address lands in the window.

Bit 0 of the register is the enable. Bits 2:1 form the length field: 00 selects 256 MiB, 01 selects 128 MiB, 10 selects 64 MiB, and 11 is reserved. The base is taken from bits 35:28. At 128 MiB, bits 27 and 26 also join the base. At 64 MiB, only bit 26 joins it. If the length field holds the reserved code, the block raises an error flag and does not decode. The register interface is a control path, so it has no back-pressure: every write with `wr_en` high is accepted on the clock edge.

Top module: `cfgwin_base_decoder`

## Requirements
- R1: While `rst_n` is low, and after reset is released, the register reads 0x0000_0000_B000_0000. The decoded outputs are then enable 0, base 0xB000_0000, size 0x1000_0000 (256 MiB) and error 0.
- R2: A write with `wr_en` high updates only the byte lanes whose `wr_be` bit is set, at the next clock edge. When `wr_en` is low, the register does not change.
- R3: The decoded outputs follow the register one clock edge after the register itself changes, which is two edges after the write is presented.
- R4: Bit 0 is the enable. When it is clear, `win_en` is 0 and `addr_hit` is 0 for every address.
- R5: When bits 2:1 are 00, the size is 0x1000_0000 and the base is the register ANDed with a mask of bits 35:28.
- R6: When bits 2:1 are 01, the size is 0x0800_0000 and the base is the register ANDed with a mask of bits 35:26. Because bit 26 lies below the window size, a base with bit 26 set can never be hit.
- R7: When bits 2:1 are 10, the size is 0x0400_0000 and the base is the register ANDed with a mask of bits 35:28 plus bit 26.
- R8: When bits 2:1 are 11, `cfg_err` is 1 and `win_en`, `win_base`, `win_size` and `addr_hit` are all 0.
- R9: `addr_hit` is high, in the same cycle as `lookup_addr`, exactly when `win_en` is set and `lookup_addr` with its low log2(size) bits cleared equals `win_base`. This means address bits 63:36 must be zero for a hit.
- R10: Register bits outside the enable, length and base fields are stored and read back, but they have no effect on the decoded outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 8 | Byte-lane enables for the write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Current register contents |
| lookup_addr | input | 64 | Address to test against the window |
| win_en | output | 1 | Window enabled and legally configured |
| win_base | output | 64 | Decoded window base |
| win_size | output | 64 | Decoded window size in bytes |
| cfg_err | output | 1 | Reserved length code is programmed |
| addr_hit | output | 1 | `lookup_addr` falls inside the window |

## Verification
The bench targets the size-dependent mask.

- A design that reused the 256 MiB mask for the smaller windows would drop bits 27 and 26 from the base. It would then report hits at addresses outside a 64 MiB window.
- The bench programs the reserved length code with the enable both set and clear. A design that decoded this code anyway would show a nonzero size or a stray hit.
- Partial byte-lane writes, and writes with the strobe low, catch designs that corrupt neighbouring lanes or ignore the enables.
- The bench samples the decoded outputs both one and two edges after a write. A design with the wrong decode latency would therefore fail at one of the two points.
- The bench also checks addresses with upper bits set, and a 128 MiB base with bit 26 set. These expose a comparator that truncates the address or compares against the wrong mask.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int CW_ADDR_W = 64;

  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } win_len_e;

  typedef struct packed {
    logic                 en;
    logic                 err;
    logic [CW_ADDR_W-1:0] base;
    logic [CW_ADDR_W-1:0] size;
  } win_dec_t;
endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg #(
  parameter int          REG_W   = 64,
  parameter logic [REG_W-1:0] RST_VAL = '0,
  localparam int         LANES   = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g*8 +: 8] <= RST_VAL[g*8 +: 8];
      end else if (wr_en && wr_be[g]) begin
        q[g*8 +: 8] <= wr_data[g*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W  = CW_ADDR_W,
  parameter int EN_BIT  = 0,
  parameter int LEN_LSB = 1,
  parameter int BASE_HI = 35,
  parameter int BASE_LO = 28,
  parameter int X128_BIT = 27,
  parameter int X64_BIT  = 26,
  parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_q,
  output win_dec_t          dec_q
);
  localparam logic [ADDR_W-1:0] ONES   = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] M_BASE = (ONES >> (ADDR_W - 1 - BASE_HI)) & (ONES << BASE_LO);
  localparam logic [ADDR_W-1:0] B128   = ADDR_W'(1) << X128_BIT;
  localparam logic [ADDR_W-1:0] B64    = ADDR_W'(1) << X64_BIT;
  localparam logic [ADDR_W-1:0] SZ256  = ADDR_W'(1) << BASE_LO;

  function automatic win_dec_t decode(input logic [ADDR_W-1:0] r);
    win_dec_t d;
    win_len_e len;
    len = win_len_e'(r[LEN_LSB +: 2]);
    d = '0;
    case (len)
      LEN_256M: begin
        d.base = r & M_BASE;
        d.size = SZ256;
      end
      LEN_128M: begin
        d.base = r & (M_BASE | B128 | B64);
        d.size = B128;
      end
      LEN_64M: begin
        d.base = r & (M_BASE | B64);
        d.size = B64;
      end
      default: begin
        d.err = 1'b1;
      end
    endcase
    d.en = r[EN_BIT] && !d.err;
    return d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_q <= decode(RST_VAL);
    else        dec_q <= decode(reg_q);
  end
endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match #(
  parameter int ADDR_W = 64
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] keep;
  always_comb begin
    keep = ~(size - ADDR_W'(1));
    hit  = en && ((addr & keep) == base);
  end
endmodule

// File: rtl/cfgwin_base_decoder.sv
module cfgwin_base_decoder
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W   = CW_ADDR_W,
  parameter int EN_BIT   = 0,
  parameter int LEN_LSB  = 1,
  parameter int BASE_HI  = 35,
  parameter int BASE_LO  = 28,
  parameter int X128_BIT = 27,
  parameter int X64_BIT  = 26,
  parameter logic [ADDR_W-1:0] RST_VAL = ADDR_W'(64'hB000_0000),
  localparam int LANES = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_size,
  output logic              cfg_err,
  output logic              addr_hit
);
  logic [ADDR_W-1:0] reg_q;
  win_dec_t          dec_q;

  cfgwin_reg #(.REG_W(ADDR_W), .RST_VAL(RST_VAL)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .q(reg_q)
  );

  cfgwin_decode #(
    .ADDR_W(ADDR_W), .EN_BIT(EN_BIT), .LEN_LSB(LEN_LSB), .BASE_HI(BASE_HI),
    .BASE_LO(BASE_LO), .X128_BIT(X128_BIT), .X64_BIT(X64_BIT), .RST_VAL(RST_VAL)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .reg_q(reg_q), .dec_q(dec_q)
  );

  cfgwin_match #(.ADDR_W(ADDR_W)) u_match (
    .en(dec_q.en), .base(dec_q.base), .size(dec_q.size),
    .addr(lookup_addr), .hit(addr_hit)
  );

  assign rd_data  = reg_q;
  assign win_en   = dec_q.en;
  assign win_base = dec_q.base;
  assign win_size = dec_q.size;
  assign cfg_err  = dec_q.err;
endmodule

// File: rtl/cfgwin_base_decoder_chk.sv
module cfgwin_base_decoder_chk #(
  parameter int ADDR_W  = 64,
  parameter int EN_BIT  = 0,
  parameter int LEN_LSB = 1,
  parameter int X64_BIT = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_data,
  input logic              win_en,
  input logic [ADDR_W-1:0] win_base,
  input logic [ADDR_W-1:0] win_size,
  input logic              cfg_err,
  input logic              addr_hit
);
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R2
  AST_ERR_FOLLOWS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err == ($past(rd_data[LEN_LSB +: 2]) == 2'b11)); // R8
  AST_EN_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    win_en == ($past(rd_data[EN_BIT]) && ($past(rd_data[LEN_LSB +: 2]) != 2'b11))); // R3
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!win_en && !addr_hit && (win_size == '0))); // R8
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !addr_hit); // R4
  AST_SIZE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> ($countones(win_size) == 1)); // R5
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    win_base[X64_BIT-1:0] == '0); // R9
endmodule

bind cfgwin_base_decoder cfgwin_base_decoder_chk #(
  .ADDR_W(ADDR_W), .EN_BIT(EN_BIT), .LEN_LSB(LEN_LSB), .X64_BIT(X64_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .win_en(win_en), .win_base(win_base), .win_size(win_size),
  .cfg_err(cfg_err), .addr_hit(addr_hit)
);

// File: tb/cfgwin_base_decoder_test.sv
`timescale 1ns/1ps
module cfgwin_base_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [63:0] lookup_addr = '0;
  logic        win_en, cfg_err, addr_hit;
  logic [63:0] win_base, win_size;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  cfgwin_base_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .lookup_addr(lookup_addr), .win_en(win_en),
    .win_base(win_base), .win_size(win_size), .cfg_err(cfg_err), .addr_hit(addr_hit)
  );

  typedef struct packed {
    logic [63:0] regv;
    logic [63:0] addr;
    logic [63:0] base;
    logic [63:0] size;
    logic        en;
    logic        err;
    logic        hit;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [0:NV-1] = '{
    '{64'h0000_0000_E000_0001, 64'h0000_0000_E123_4567, 64'h0000_0000_E000_0000, 64'h1000_0000, 1'b1, 1'b0, 1'b1}, // R5 hit
    '{64'h0000_0000_E000_0001, 64'h0000_0000_F000_0000, 64'h0000_0000_E000_0000, 64'h1000_0000, 1'b1, 1'b0, 1'b0}, // R5 miss
    '{64'h0000_0000_8800_0003, 64'h0000_0000_8FFF_FFFF, 64'h0000_0000_8800_0000, 64'h0800_0000, 1'b1, 1'b0, 1'b1}, // R6 hit
    '{64'h0000_0000_8C00_0003, 64'h0000_0000_8C00_0000, 64'h0000_0000_8C00_0000, 64'h0800_0000, 1'b1, 1'b0, 1'b0}, // R6 bit26 base
    '{64'h0000_000F_D400_0005, 64'h0000_000F_D7FF_FFFF, 64'h0000_000F_D400_0000, 64'h0400_0000, 1'b1, 1'b0, 1'b1}, // R7 hit
    '{64'h0000_000F_D400_0005, 64'h0000_000F_D800_0000, 64'h0000_000F_D400_0000, 64'h0400_0000, 1'b1, 1'b0, 1'b0}, // R7 miss
    '{64'hABCD_0000_1FFF_FFF9, 64'h0000_0000_1ABC_0000, 64'h0000_0000_1000_0000, 64'h1000_0000, 1'b1, 1'b0, 1'b1}, // R10 extra bits
    '{64'hABCD_0000_1FFF_FFF9, 64'hABCD_0000_1000_0000, 64'h0000_0000_1000_0000, 64'h1000_0000, 1'b1, 1'b0, 1'b0}, // R9 upper bits
    '{64'h0000_0000_E000_0000, 64'h0000_0000_E000_0000, 64'h0000_0000_E000_0000, 64'h1000_0000, 1'b0, 1'b0, 1'b0}, // R4 off
    '{64'h0000_0000_E000_0007, 64'h0000_0000_E000_0000, 64'h0, 64'h0, 1'b0, 1'b1, 1'b0},                             // R8 on
    '{64'h0000_0000_E000_0006, 64'h0000_0000_E000_0000, 64'h0, 64'h0, 1'b0, 1'b1, 1'b0}                              // R8 off
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] d, input logic [7:0] be, input logic en);
    @(negedge clk);
    wr_en = en; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  task automatic chk_reset_state(input string tag);
    chk({tag, " rd_data"}, rd_data, 64'hB000_0000);
    chk({tag, " win_en"}, {63'b0, win_en}, 64'h0);
    chk({tag, " win_base"}, win_base, 64'hB000_0000);
    chk({tag, " win_size"}, win_size, 64'h1000_0000);
    chk({tag, " cfg_err"}, {63'b0, cfg_err}, 64'h0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk_reset_state("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_reset_state("R1 after reset");
    lookup_addr = 64'hB000_0000;
    #1 chk("R4 default disabled hit", {63'b0, addr_hit}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].regv, 8'hFF, 1'b1);
      @(negedge clk);
      lookup_addr = VEC[i].addr;
      #1;
      chk($sformatf("R2 v%0d rd_data", i), rd_data, VEC[i].regv);
      chk($sformatf("R5-7 v%0d base", i), win_base, VEC[i].base);
      chk($sformatf("R5-7 v%0d size", i), win_size, VEC[i].size);
      chk($sformatf("R4 v%0d en", i), {63'b0, win_en}, {63'b0, VEC[i].en});
      chk($sformatf("R8 v%0d err", i), {63'b0, cfg_err}, {63'b0, VEC[i].err});
      chk($sformatf("R9 v%0d hit", i), {63'b0, addr_hit}, {63'b0, VEC[i].hit});
    end

    // Reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk_reset_state("R1 re-reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 byte lane 0 only, R3 latency
    wr(64'hFFFF_FFFF_FFFF_FF03, 8'h01, 1'b1);
    chk("R2 lane0 write", rd_data, 64'h0000_0000_B000_0003);
    chk("R3 size not yet updated", win_size, 64'h1000_0000);
    chk("R3 en not yet updated", {63'b0, win_en}, 64'h0);
    @(negedge clk);
    chk("R3 size after decode", win_size, 64'h0800_0000);
    chk("R3 en after decode", {63'b0, win_en}, 64'h1);
    chk("R6 base lane0", win_base, 64'hB000_0000);

    // R2 lane 4 only
    wr(64'h0000_0005_0000_0000, 8'h10, 1'b1);
    @(negedge clk);
    chk("R2 lane4 write", rd_data, 64'h0000_0005_B000_0003);
    chk("R6 base lane4", win_base, 64'h0000_0005_B000_0000);
    lookup_addr = 64'h0000_0005_B7FF_FFFF;
    #1 chk("R9 hit high base", {63'b0, addr_hit}, 64'h1);

    // R2 strobe low ignored
    wr(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0);
    @(negedge clk);
    chk("R2 strobe low rd_data", rd_data, 64'h0000_0005_B000_0003);
    chk("R2 strobe low base", win_base, 64'h0000_0005_B000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule